// File: doc/BRIEF.md
# Bus Transceiver Direction Steering Controller

This block is the synchronous steering logic of a nine-lane bidirectional bridge that joins a single-ended side (A) to a differential side (B). The nine lanes are eight data bits and a parity bit; parity is treated exactly like data and is never checked. For each side the block receives, per lane, a flag that the line is sensed asserted. For each lane it returns a driver enable for the A side, a driver enable for the B side, and the value each enabled driver should place on its line.

Two steering schemes exist. In autonomous mode (`directed_mode` low) every lane has its own latch. A lane that is quiet on both sides is IDLE. The first side seen asserted wins, and the opposite side's driver is turned on. The lane stays in that direction until both sides read deasserted. In directed mode (`directed_mode` high) one direction applies to all nine lanes and comes from `sel_b2a`. The value present when the mode is entered takes effect at once. A later change of `sel_b2a` turns every driver off, and the new direction waits until all nine lanes read quiet on both sides. Any fault input forces every driver off and clears all steering state.

Every input passes through a two-flop synchronizer, and the steering state is a register. A change at an input therefore reaches the outputs on the third rising clock edge after it.

Per-lane states are LANE_IDLE, LANE_A2B and LANE_B2A:
- LANE_IDLE goes to LANE_A2B when A is asserted. A wins if both sides are asserted together.
- LANE_IDLE goes to LANE_B2A when only B is asserted.
- LANE_A2B and LANE_B2A go back to LANE_IDLE when both sides read deasserted.
- Any state goes to LANE_IDLE on a fault or while directed mode is active.

Directed states are DIR_OFF, DIR_A2B, DIR_B2A and DIR_TURN:
- DIR_OFF goes to DIR_A2B or DIR_B2A, chosen by the select, on the first cycle the mode is active with no fault.
- DIR_A2B goes to DIR_TURN when the select reads 1.
- DIR_B2A goes to DIR_TURN when the select reads 0.
- DIR_TURN goes to the direction the select names once no lane is asserted on either side.
- Any state goes to DIR_OFF on a fault or when the mode drops.

Top module: `bus_dir_steer`

## Requirements
- R1: All nine lanes, bit 8 (parity) included, are steered by the same rules, and no lane's value is checked or altered.
- R2: After reset, and in autonomous mode whenever a lane is not asserted on either side, both of that lane's enables are 0.
- R3: In autonomous mode, an idle lane asserted on A only sets its B enable three clock edges later. An idle lane asserted on B only sets its A enable three clock edges later. A lane never has both enables set.
- R4: Lanes are independent: different lanes may be steered in opposite directions at the same time.
- R5: Once steered, a lane keeps its direction while either side is still asserted. It returns to idle only when both sides read deasserted.
- R6: When an idle lane sees A and B asserted in the same cycle, it steers A to B.
- R7: On entering directed mode, the select takes effect on the third edge with no wait. A select of 1 sets all nine A enables; a select of 0 sets all nine B enables. This holds even while lanes are busy.
- R8: A select change inside directed mode clears every enable. Enables stay clear while any lane is asserted on either side. Once all lanes are quiet, the set that the select names turns on.
- R9: Any of `ext_reset_n` low, `cable_ok` low, `pwr_not_ready` high or `over_temp` high clears all enables and all steering state.
- R10: An enabled A driver carries the synchronized B sense of its lane. An enabled B driver carries the synchronized A sense. A disabled driver's value is 0.
- R11: Leaving directed mode turns all enables off and leaves every lane latch idle, ready for autonomous steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_reset_n | input | 1 | External bus reset, active low |
| cable_ok | input | 1 | Cable-type sense; low means wrong cable, forces off |
| pwr_not_ready | input | 1 | Supply not ready, forces off |
| over_temp | input | 1 | Over-temperature, forces off |
| directed_mode | input | 1 | 1 = direction from select, 0 = per-lane autonomous |
| sel_b2a | input | 1 | Directed select: 1 = B to A, 0 = A to B |
| a_sense | input | 9 | Per-lane A-side asserted sense |
| b_sense | input | 9 | Per-lane B-side asserted sense |
| a_drv_en | output | 9 | Per-lane A-side driver enable |
| b_drv_en | output | 9 | Per-lane B-side driver enable |
| a_drv_val | output | 9 | Value driven on A lines |
| b_drv_val | output | 9 | Value driven on B lines |

## Verification
A lane latch stuck in a wrong state shows at the ports as an enable on the wrong side, or as an enable that does not drop. This appears on the third edge after the sense pattern that should have moved the lane. Releasing both sides of a lane exposes a stuck hold state within three edges. A directed controller that skips DIR_TURN turns on the new driver set while lanes are still busy, visible three edges after the select flips. Holding lanes busy for several cycles during a turnaround exposes an early exit. A latch that a fault failed to clear shows after release: both sides asserted then steer B to A instead of A to B.

// File: rtl/bds_pkg.sv
package bds_pkg;
    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_A2B  = 2'd1,
        LANE_B2A  = 2'd2
    } lane_st_t;

    typedef enum logic [1:0] {
        DIR_OFF  = 2'd0,
        DIR_A2B  = 2'd1,
        DIR_B2A  = 2'd2,
        DIR_TURN = 2'd3
    } dir_st_t;
endpackage

// File: rtl/bds_sync.sv
module bds_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bds_lane.sv
module bds_lane
    import bds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic a_s,
    input  logic b_s,
    output logic a_en_q,
    output logic b_en_q
);
    lane_st_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (clr) begin
            nxt = LANE_IDLE;
        end else begin
            unique case (cur)
                LANE_IDLE: begin
                    if (a_s)      nxt = LANE_A2B;
                    else if (b_s) nxt = LANE_B2A;
                end
                LANE_A2B:  if (!a_s && !b_s) nxt = LANE_IDLE;
                LANE_B2A:  if (!a_s && !b_s) nxt = LANE_IDLE;
                default:   nxt = LANE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= LANE_IDLE;
        else        cur <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_en_q <= 1'b0;
            b_en_q <= 1'b0;
        end else begin
            a_en_q <= (nxt == LANE_B2A);
            b_en_q <= (nxt == LANE_A2B);
        end
    end

    AST_IDLE_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == LANE_IDLE && a_s && !clr) |=> (b_en_q && !a_en_q)); // R3
    AST_TIE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == LANE_IDLE && a_s && b_s && !clr) |=> !a_en_q); // R6
    AST_HOLD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == LANE_A2B && b_s && !clr) |=> b_en_q); // R5
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!a_en_q && !b_en_q)); // R9
endmodule

// File: rtl/bds_dir.sv
module bds_dir
    import bds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic mode_s,
    input  logic sel_s,
    input  logic busy,
    output logic a_all_q,
    output logic b_all_q
);
    dir_st_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (kill || !mode_s) begin
            nxt = DIR_OFF;
        end else begin
            unique case (cur)
                DIR_OFF:  nxt = sel_s ? DIR_B2A : DIR_A2B;
                DIR_A2B:  if (sel_s)  nxt = DIR_TURN;
                DIR_B2A:  if (!sel_s) nxt = DIR_TURN;
                DIR_TURN: if (!busy)  nxt = sel_s ? DIR_B2A : DIR_A2B;
                default:  nxt = DIR_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= DIR_OFF;
        else        cur <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_all_q <= 1'b0;
            b_all_q <= 1'b0;
        end else begin
            a_all_q <= (nxt == DIR_B2A);
            b_all_q <= (nxt == DIR_A2B);
        end
    end

    AST_ENTRY_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == DIR_OFF && mode_s && !kill && sel_s) |=> a_all_q); // R7
    AST_FLIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == DIR_A2B && mode_s && !kill && sel_s) |=> (!a_all_q && !b_all_q)); // R8
    AST_TURN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == DIR_TURN && busy) |=> (!a_all_q && !b_all_q)); // R8
endmodule

// File: rtl/bus_dir_steer.sv
module bus_dir_steer #(
    parameter int LANES  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_reset_n,
    input  logic             cable_ok,
    input  logic             pwr_not_ready,
    input  logic             over_temp,
    input  logic             directed_mode,
    input  logic             sel_b2a,
    input  logic [LANES-1:0] a_sense,
    input  logic [LANES-1:0] b_sense,
    output logic [LANES-1:0] a_drv_en,
    output logic [LANES-1:0] b_drv_en,
    output logic [LANES-1:0] a_drv_val,
    output logic [LANES-1:0] b_drv_val
);
    localparam int NFLT = 4;
    localparam int SW   = 2 * LANES;

    logic [NFLT-1:0]  fault_raw, fault_s;
    logic [SW-1:0]    sense_s;
    logic [1:0]       ctl_s;
    logic [LANES-1:0] a_s, b_s, a_q, b_q;
    logic [LANES-1:0] lane_a_en, lane_b_en;
    logic             kill, mode_s, sel_s, busy, dir_a, dir_b;

    assign fault_raw = {over_temp, pwr_not_ready, ~cable_ok, ~ext_reset_n};

    bds_sync #(.W(NFLT), .STAGES(STAGES), .RST_VAL({NFLT{1'b1}})) u_sync_flt (
        .clk(clk), .rst_n(rst_n), .d(fault_raw), .q(fault_s));
    bds_sync #(.W(SW), .STAGES(STAGES), .RST_VAL({SW{1'b0}})) u_sync_sense (
        .clk(clk), .rst_n(rst_n), .d({b_sense, a_sense}), .q(sense_s));
    bds_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({directed_mode, sel_b2a}), .q(ctl_s));

    assign kill   = |fault_s;
    assign a_s    = sense_s[LANES-1:0];
    assign b_s    = sense_s[SW-1:LANES];
    assign mode_s = ctl_s[1];
    assign sel_s  = ctl_s[0];
    assign busy   = |{a_s, b_s};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            bds_lane u_lane (
                .clk(clk), .rst_n(rst_n), .clr(kill | mode_s),
                .a_s(a_s[g]), .b_s(b_s[g]),
                .a_en_q(lane_a_en[g]), .b_en_q(lane_b_en[g]));
        end
    endgenerate

    bds_dir u_dir (
        .clk(clk), .rst_n(rst_n), .kill(kill), .mode_s(mode_s),
        .sel_s(sel_s), .busy(busy), .a_all_q(dir_a), .b_all_q(dir_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    assign a_drv_en  = lane_a_en | {LANES{dir_a}};
    assign b_drv_en  = lane_b_en | {LANES{dir_b}};
    assign a_drv_val = a_drv_en & b_q;
    assign b_drv_val = b_drv_en & a_q;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv_en & b_drv_en) == '0); // R3
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (a_drv_en == '0 && b_drv_en == '0)); // R9
    AST_LANES_QUIET_DIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |=> (lane_a_en == '0 && lane_b_en == '0)); // R11
    AST_VAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (b_drv_val == (b_drv_en & $past(a_s)))); // R10
endmodule

// File: tb/tb_bus_dir_steer.sv
module tb_bus_dir_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_reset_n = 1'b1, cable_ok = 1'b1, pwr_not_ready = 1'b0, over_temp = 1'b0;
    logic       directed_mode = 1'b0, sel_b2a = 1'b0;
    logic [8:0] a_sense = '0, b_sense = '0;
    logic [8:0] a_drv_en, b_drv_en, a_drv_val, b_drv_val;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    bus_dir_steer dut (
        .clk(clk), .rst_n(rst_n), .ext_reset_n(ext_reset_n), .cable_ok(cable_ok),
        .pwr_not_ready(pwr_not_ready), .over_temp(over_temp),
        .directed_mode(directed_mode), .sel_b2a(sel_b2a),
        .a_sense(a_sense), .b_sense(b_sense),
        .a_drv_en(a_drv_en), .b_drv_en(b_drv_en),
        .a_drv_val(a_drv_val), .b_drv_val(b_drv_val));

    task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] a, input logic [8:0] b);
        @(negedge clk);
        a_sense = a;
        b_sense = b;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R2", "a_en after reset", a_drv_en, 9'h000);
        chk("R2", "b_en after reset", b_drv_en, 9'h000);
    endtask

    task automatic t_autonomous_basic();
        drive(9'h001, 9'h000); settle();
        chk("R3", "b_en A asserted", b_drv_en, 9'h001);
        chk("R3", "a_en A asserted", a_drv_en, 9'h000);
        chk("R10", "b_val", b_drv_val, 9'h001);
        drive(9'h000, 9'h000); settle();
        chk("R2", "b_en idle", b_drv_en, 9'h000);
        drive(9'h000, 9'h100); settle();
        chk("R1", "parity lane a_en", a_drv_en, 9'h100);
        chk("R10", "parity a_val", a_drv_val, 9'h100);
        drive(9'h000, 9'h000); settle();
    endtask

    task automatic t_independent();
        drive(9'h00F, 9'h0F0); settle();
        chk("R4", "b_en mixed", b_drv_en, 9'h00F);
        chk("R4", "a_en mixed", a_drv_en, 9'h0F0);
        drive(9'h000, 9'h000); settle();
    endtask

    task automatic t_hold();
        drive(9'h001, 9'h000); settle();
        drive(9'h001, 9'h001); settle();
        chk("R5", "hold both asserted", b_drv_en, 9'h001);
        drive(9'h000, 9'h001); settle();
        chk("R5", "hold origin released", b_drv_en, 9'h001);
        chk("R5", "no reverse", a_drv_en, 9'h000);
        chk("R10", "b_val follows A low", b_drv_val, 9'h000);
        drive(9'h000, 9'h000); settle();
        chk("R5", "released", b_drv_en, 9'h000);
    endtask

    task automatic t_tie();
        drive(9'h010, 9'h010); settle();
        chk("R6", "tie b_en", b_drv_en, 9'h010);
        chk("R6", "tie a_en", a_drv_en, 9'h000);
        drive(9'h000, 9'h000); settle();
    endtask

    task automatic t_fault();
        drive(9'h000, 9'h002); settle();
        drive(9'h002, 9'h002); settle();
        chk("R9", "pre-fault B2A held", a_drv_en, 9'h002);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            case (k)
                0: ext_reset_n = 1'b0;
                1: cable_ok = 1'b0;
                2: pwr_not_ready = 1'b1;
                default: over_temp = 1'b1;
            endcase
            settle();
            chk("R9", "fault a_en", a_drv_en, 9'h000);
            chk("R9", "fault b_en", b_drv_en, 9'h000);
            @(negedge clk);
            ext_reset_n = 1'b1; cable_ok = 1'b1; pwr_not_ready = 1'b0; over_temp = 1'b0;
            settle();
            chk("R9", "latch cleared, tie to A2B", b_drv_en, 9'h002);
        end
        drive(9'h000, 9'h000); settle();
    endtask

    task automatic t_directed();
        drive(9'h0F0, 9'h000); settle();
        @(negedge clk); directed_mode = 1'b1; sel_b2a = 1'b1;
        settle();
        chk("R7", "entry a_en while busy", a_drv_en, 9'h1FF);
        chk("R7", "entry b_en", b_drv_en, 9'h000);
        drive(9'h000, 9'h055); settle();
        chk("R10", "directed a_val", a_drv_val, 9'h055);
        @(negedge clk); sel_b2a = 1'b0;
        settle();
        chk("R8", "turn all off a", a_drv_en, 9'h000);
        chk("R8", "turn all off b", b_drv_en, 9'h000);
        repeat (6) @(posedge clk); #1;
        chk("R8", "still off while busy", b_drv_en, 9'h000);
        drive(9'h000, 9'h000); settle();
        chk("R8", "new set on", b_drv_en, 9'h1FF);
        chk("R8", "old set off", a_drv_en, 9'h000);
        @(negedge clk); directed_mode = 1'b0;
        settle();
        chk("R11", "exit b_en", b_drv_en, 9'h000);
        drive(9'h004, 9'h000); settle();
        chk("R11", "autonomous resumes", b_drv_en, 9'h004);
        drive(9'h000, 9'h000); settle();
        @(negedge clk); directed_mode = 1'b1;
        settle();
        chk("R7", "entry select 0", b_drv_en, 9'h1FF);
        @(negedge clk); directed_mode = 1'b0;
        settle();
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        repeat (5) @(posedge clk);
        t_autonomous_basic();
        t_independent();
        t_hold();
        t_tie();
        t_fault();
        t_directed();
        finish_run();
    end
endmodule